// File: doc/BRIEF.md
# Terminal Register Editor

This block sits between a UART byte stream and an I2C command sequencer. It takes ASCII keystrokes from the UART receiver and keeps an editable command line of six hex digits. The digits are the device address, the register address and the data byte, in that order. Accepted characters are echoed to the UART transmitter. A command reaches the sequencer only when the operator presses Enter on a complete line.

Every command the sequencer executes is handed back to the block. The block prints it as hex text and loads it into the edit line. After power-up the operator therefore sees the startup table scroll past, and the last command stays on the line, ready to edit. When a read command finishes, the byte that was read back is printed. Single keys flip the device address between its write form and its read form, and ESC asks the system to run the startup table again.

All three inputs (keystrokes, executed-command log, read data) use a valid/ready handshake. Output bytes wait for the transmitter's ready, so bursts of log lines lose nothing.

Top module: `ted_term_editor`

## Requirements
- R1: After reset, tx_valid_o, cmd_valid_o and reinit_o are low, rx_ready_o is high, and the edit line is empty: an Enter key issues no command and prints nothing.
- R2: An accepted log entry (log_dev_i, log_reg_i, log_dat_i) is printed as six upper-case hex digits (device high, device low, register high, register low, data high, data low) followed by 0x0D 0x0A. It then replaces the edit line, which becomes full.
- R3: Hex keys 0x30-0x39, 0x41-0x46 and 0x61-0x66 append one digit while the line holds fewer than six digits, and each appended digit is echoed as its upper-case character. On a full line such a key is ignored without echo. Digit order is the same as in R2.
- R4: Backspace (0x08 or 0x7F) on a non-empty line removes the last digit and emits 0x08 0x20 0x08. On an empty line it does nothing.
- R5: W or w (0x57/0x77) clears bit 0 of the stored device address, and R or r (0x52/0x72) sets it. This happens even if that digit has not been entered yet. Either key then emits 0x0D followed by the digits currently on the line.
- R6: Enter (0x0D) on a full line presents the device, register and data on the command port, with cmd_read_o equal to device bit 0. The command is held until cmd_ready_i and then followed by the output 0x0D 0x0A. Enter on a line that is not full does nothing.
- R7: Any other character is discarded without echo and leaves the line unchanged.
- R8: ESC (0x1B) raises reinit_o for exactly one cycle, empties the edit line and emits 0x0D 0x0A.
- R9: Accepted read data is printed as two upper-case hex digits followed by 0x0D 0x0A.
- R10: At most one input is accepted at a time, and only while nothing is printing and no command is pending. When several inputs are waiting, read data goes first, then the log entry, then the keystroke.
- R11: Once tx_valid_o is high, it and tx_data_o stay unchanged until tx_ready_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Keystroke available |
| rx_data_i | input | 8 | Keystroke ASCII code |
| rx_ready_o | output | 1 | Keystroke accepted |
| log_valid_i | input | 1 | Executed command available |
| log_dev_i | input | DEV_W | Executed command device address |
| log_reg_i | input | REG_W | Executed command register address |
| log_dat_i | input | DAT_W | Executed command data |
| log_ready_o | output | 1 | Log entry accepted |
| rd_valid_i | input | 1 | Read-back data available |
| rd_data_i | input | DAT_W | Read-back data |
| rd_ready_o | output | 1 | Read data accepted |
| tx_valid_o | output | 1 | Output character valid |
| tx_data_o | output | 8 | Output character |
| tx_ready_i | input | 1 | Transmitter takes the character |
| cmd_valid_o | output | 1 | Command to sequencer valid |
| cmd_dev_o | output | DEV_W | Command device address |
| cmd_reg_o | output | REG_W | Command register address |
| cmd_dat_o | output | DAT_W | Command data |
| cmd_read_o | output | 1 | Command is a read (device bit 0) |
| cmd_ready_i | input | 1 | Sequencer takes the command |
| reinit_o | output | 1 | One-cycle request to rerun the startup table |

## Verification
Directed key sequences cover the cases a random stream rarely hits: an empty line, a full line, W/R on a partly entered line, and backspace on an empty line. Upper-case and lower-case hex letters are mixed, so a decoder that handles only one case produces wrong echo. A random stream of hex digits, edit keys, Enter, ESC, junk, log entries and read data is replayed against a line model in the bench. This separates the byte order of the output, the digit position of each field and the placement of the read/write bit. Firing read data, a log entry and a keystroke in the same cycle exposes the acceptance order. Random stalls on the transmitter and command ready check that nothing is dropped or repeated.

// File: rtl/ted_pkg.sv
`timescale 1ns/1ps
package ted_pkg;
  typedef enum logic [2:0] {K_NONE, K_HEX, K_WR, K_RD, K_BS, K_ENT, K_ESC} key_e;
  typedef enum logic [2:0] {J_ECHO, J_BKSP, J_REDRAW, J_CRLF, J_LOG, J_RDDAT} job_e;

  localparam logic [7:0] CH_CR  = 8'h0D;
  localparam logic [7:0] CH_LF  = 8'h0A;
  localparam logic [7:0] CH_BS  = 8'h08;
  localparam logic [7:0] CH_SP  = 8'h20;
  localparam logic [7:0] CH_DEL = 8'h7F;
  localparam logic [7:0] CH_ESC = 8'h1B;

  function automatic logic [7:0] nib2asc(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction
endpackage

// File: rtl/ted_key_decode.sv
`timescale 1ns/1ps
module ted_key_decode
  import ted_pkg::*;
(
  input  logic [7:0] char_i,
  output key_e       key_o,
  output logic [3:0] nib_o
);
  always_comb begin
    key_o = K_NONE;
    nib_o = '0;
    if (char_i >= 8'h30 && char_i <= 8'h39) begin
      key_o = K_HEX;
      nib_o = char_i[3:0];
    end else if ((char_i >= 8'h41 && char_i <= 8'h46) ||
                 (char_i >= 8'h61 && char_i <= 8'h66)) begin
      key_o = K_HEX;
      nib_o = char_i[3:0] + 4'd9;
    end else begin
      case (char_i)
        8'h57, 8'h77:  key_o = K_WR;
        8'h52, 8'h72:  key_o = K_RD;
        CH_BS, CH_DEL: key_o = K_BS;
        CH_CR:         key_o = K_ENT;
        CH_ESC:        key_o = K_ESC;
        default:       key_o = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ted_line_buf.sv
`timescale 1ns/1ps
module ted_line_buf #(
  parameter int DEV_W = 8,
  parameter int REG_W = 8,
  parameter int DAT_W = 8,
  localparam int LINE_W = DEV_W + REG_W + DAT_W,
  localparam int LINE_N = LINE_W / 4,
  localparam int CW     = $clog2(LINE_N + 1),
  localparam int RW_POS = REG_W + DAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LINE_W-1:0] load_val_i,
  input  logic              push_i,
  input  logic [3:0]        nib_i,
  input  logic              pop_i,
  input  logic              set_rw_i,
  input  logic              rw_val_i,
  input  logic              clear_i,
  output logic [LINE_W-1:0] line_o,
  output logic [CW-1:0]     cnt_o,
  output logic              full_o
);
  logic [LINE_W-1:0] line_q;
  logic [CW-1:0]     cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      line_q <= load_val_i;
      cnt_q  <= CW'(LINE_N);
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (push_i && !full_o) begin
      for (int k = 0; k < LINE_N; k++)
        if (cnt_q == CW'(k)) line_q[LINE_W-1-4*k -: 4] <= nib_i;
      cnt_q <= cnt_q + CW'(1);
    end else if (pop_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end else if (set_rw_i) begin
      line_q[RW_POS] <= rw_val_i;
    end
  end

  assign line_o = line_q;
  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CW'(LINE_N));
endmodule

// File: rtl/ted_tx_fmt.sv
`timescale 1ns/1ps
module ted_tx_fmt
  import ted_pkg::*;
#(
  parameter int LINE_N = 6,
  parameter int DAT_W  = 8,
  localparam int LINE_W = LINE_N * 4,
  localparam int RD_N   = DAT_W / 4,
  localparam int CW     = $clog2(LINE_N + 1),
  localparam int IW     = $clog2(LINE_N + 3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  job_e              job_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic [7:0]        echo_i,
  input  logic [DAT_W-1:0]  rd_i,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              busy_o
);
  logic          busy_q;
  job_e          job_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] len;

  function automatic logic [3:0] line_nib(input logic [IW-1:0] k);
    logic [3:0] n = '0;
    for (int i = 0; i < LINE_N; i++)
      if (k == IW'(i)) n = line_i[LINE_W-1-4*i -: 4];
    return n;
  endfunction

  function automatic logic [3:0] rd_nib(input logic [IW-1:0] k);
    logic [3:0] n = '0;
    for (int i = 0; i < RD_N; i++)
      if (k == IW'(i)) n = rd_i[DAT_W-1-4*i -: 4];
    return n;
  endfunction

  always_comb begin
    case (job_q)
      J_ECHO:   len = IW'(1);
      J_BKSP:   len = IW'(3);
      J_REDRAW: len = IW'(cnt_i) + IW'(1);
      J_CRLF:   len = IW'(2);
      J_LOG:    len = IW'(LINE_N + 2);
      default:  len = IW'(RD_N + 2);
    endcase
  end

  always_comb begin
    case (job_q)
      J_ECHO:   tx_data_o = echo_i;
      J_BKSP:   tx_data_o = (idx_q == IW'(1)) ? CH_SP : CH_BS;
      J_REDRAW: tx_data_o = (idx_q == '0) ? CH_CR : nib2asc(line_nib(idx_q - IW'(1)));
      J_CRLF:   tx_data_o = (idx_q == '0) ? CH_CR : CH_LF;
      J_LOG:    tx_data_o = (idx_q < IW'(LINE_N)) ? nib2asc(line_nib(idx_q)) :
                            (idx_q == IW'(LINE_N)) ? CH_CR : CH_LF;
      default:  tx_data_o = (idx_q < IW'(RD_N)) ? nib2asc(rd_nib(idx_q)) :
                            (idx_q == IW'(RD_N)) ? CH_CR : CH_LF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      job_q  <= J_CRLF;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      job_q  <= job_i;
      idx_q  <= '0;
    end else if (busy_q && tx_ready_i) begin
      if (idx_q == len - IW'(1)) busy_q <= 1'b0;
      else                        idx_q  <= idx_q + IW'(1);
    end
  end

  assign tx_valid_o = busy_q;
  assign busy_o     = busy_q;
endmodule

// File: rtl/ted_term_editor.sv
`timescale 1ns/1ps
module ted_term_editor
  import ted_pkg::*;
#(
  parameter int DEV_W = 8,
  parameter int REG_W = 8,
  parameter int DAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  output logic             rx_ready_o,
  input  logic             log_valid_i,
  input  logic [DEV_W-1:0] log_dev_i,
  input  logic [REG_W-1:0] log_reg_i,
  input  logic [DAT_W-1:0] log_dat_i,
  output logic             log_ready_o,
  input  logic             rd_valid_i,
  input  logic [DAT_W-1:0] rd_data_i,
  output logic             rd_ready_o,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  input  logic             tx_ready_i,
  output logic             cmd_valid_o,
  output logic [DEV_W-1:0] cmd_dev_o,
  output logic [REG_W-1:0] cmd_reg_o,
  output logic [DAT_W-1:0] cmd_dat_o,
  output logic             cmd_read_o,
  input  logic             cmd_ready_i,
  output logic             reinit_o
);
  localparam int LINE_W = DEV_W + REG_W + DAT_W;
  localparam int LINE_N = LINE_W / 4;
  localparam int CW     = $clog2(LINE_N + 1);

  typedef enum logic {S_IDLE, S_CMD} st_e;

  st_e               state_q, state_d;
  logic              fmt_busy;
  logic              idle_free;
  logic              rx_acc, log_acc, rd_acc;
  key_e              key;
  logic [3:0]        key_nib;
  logic [LINE_W-1:0] line;
  logic [CW-1:0]     line_cnt;
  logic              line_full;
  logic              lb_load, lb_push, lb_pop, lb_set_rw, lb_rw_val, lb_clear;
  logic              fmt_start;
  job_e              fmt_job;
  logic              esc_hit;
  logic              reinit_q;
  logic [7:0]        echo_q;
  logic [DAT_W-1:0]  rd_q;

  ted_key_decode i_dec (
    .char_i (rx_data_i),
    .key_o  (key),
    .nib_o  (key_nib)
  );

  ted_line_buf #(.DEV_W(DEV_W), .REG_W(REG_W), .DAT_W(DAT_W)) i_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (lb_load),
    .load_val_i ({log_dev_i, log_reg_i, log_dat_i}),
    .push_i     (lb_push),
    .nib_i      (key_nib),
    .pop_i      (lb_pop),
    .set_rw_i   (lb_set_rw),
    .rw_val_i   (lb_rw_val),
    .clear_i    (lb_clear),
    .line_o     (line),
    .cnt_o      (line_cnt),
    .full_o     (line_full)
  );

  ted_tx_fmt #(.LINE_N(LINE_N), .DAT_W(DAT_W)) i_fmt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (fmt_start),
    .job_i      (fmt_job),
    .line_i     (line),
    .cnt_i      (line_cnt),
    .echo_i     (echo_q),
    .rd_i       (rd_q),
    .tx_ready_i (tx_ready_i),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .busy_o     (fmt_busy)
  );

  // fixed acceptance order: read data, log, keystroke
  assign idle_free   = (state_q == S_IDLE) && !fmt_busy;
  assign rd_ready_o  = idle_free;
  assign log_ready_o = idle_free && !rd_valid_i;
  assign rx_ready_o  = idle_free && !rd_valid_i && !log_valid_i;
  assign rd_acc      = rd_valid_i && rd_ready_o;
  assign log_acc     = log_valid_i && log_ready_o;
  assign rx_acc      = rx_valid_i && rx_ready_o;

  always_comb begin
    state_d   = state_q;
    lb_load   = 1'b0;
    lb_push   = 1'b0;
    lb_pop    = 1'b0;
    lb_set_rw = 1'b0;
    lb_rw_val = 1'b0;
    lb_clear  = 1'b0;
    fmt_start = 1'b0;
    fmt_job   = J_CRLF;
    esc_hit   = 1'b0;
    if (state_q == S_CMD) begin
      if (cmd_ready_i) begin
        fmt_start = 1'b1;
        state_d   = S_IDLE;
      end
    end else if (rd_acc) begin
      fmt_start = 1'b1;
      fmt_job   = J_RDDAT;
    end else if (log_acc) begin
      lb_load   = 1'b1;
      fmt_start = 1'b1;
      fmt_job   = J_LOG;
    end else if (rx_acc) begin
      case (key)
        K_HEX: if (!line_full) begin
          lb_push   = 1'b1;
          fmt_start = 1'b1;
          fmt_job   = J_ECHO;
        end
        K_WR, K_RD: begin
          lb_set_rw = 1'b1;
          lb_rw_val = (key == K_RD);
          fmt_start = 1'b1;
          fmt_job   = J_REDRAW;
        end
        K_BS: if (line_cnt != '0) begin
          lb_pop    = 1'b1;
          fmt_start = 1'b1;
          fmt_job   = J_BKSP;
        end
        K_ENT: if (line_full) state_d = S_CMD;
        K_ESC: begin
          lb_clear  = 1'b1;
          esc_hit   = 1'b1;
          fmt_start = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      reinit_q <= 1'b0;
      echo_q   <= '0;
      rd_q     <= '0;
    end else begin
      state_q  <= state_d;
      reinit_q <= esc_hit;
      if (lb_push) echo_q <= nib2asc(key_nib);
      if (rd_acc)  rd_q   <= rd_data_i;
    end
  end

  assign cmd_valid_o = (state_q == S_CMD);
  assign cmd_dev_o   = line[LINE_W-1 -: DEV_W];
  assign cmd_reg_o   = line[REG_W+DAT_W-1 -: REG_W];
  assign cmd_dat_o   = line[DAT_W-1:0];
  assign cmd_read_o  = line[REG_W+DAT_W];
  assign reinit_o    = reinit_q;
endmodule

// File: rtl/ted_term_editor_chk.sv
`timescale 1ns/1ps
module ted_term_editor_chk #(
  parameter int DEV_W = 8,
  parameter int REG_W = 8,
  parameter int DAT_W = 8,
  localparam int LINE_N = (DEV_W + REG_W + DAT_W) / 4,
  localparam int CW     = $clog2(LINE_N + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_valid_o,
  input logic [7:0]       tx_data_o,
  input logic             tx_ready_i,
  input logic             cmd_valid_o,
  input logic [DEV_W-1:0] cmd_dev_o,
  input logic [REG_W-1:0] cmd_reg_o,
  input logic [DAT_W-1:0] cmd_dat_o,
  input logic             cmd_ready_i,
  input logic             reinit_o,
  input logic             rx_acc,
  input logic             log_acc,
  input logic             rd_acc,
  input logic [CW-1:0]    line_cnt
);
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)); // R11
  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable({cmd_dev_o, cmd_reg_o, cmd_dat_o})); // R6
  AST_CMD_FULL_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> line_cnt == CW'(LINE_N) && !tx_valid_o); // R6
  AST_REINIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_o |=> !reinit_o); // R8
  AST_ACCEPT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_acc || log_acc || rd_acc) |-> !tx_valid_o && !cmd_valid_o); // R10
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_cnt <= CW'(LINE_N)); // R3
endmodule

bind ted_term_editor ted_term_editor_chk #(.DEV_W(DEV_W), .REG_W(REG_W), .DAT_W(DAT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_valid_o  (tx_valid_o),
  .tx_data_o   (tx_data_o),
  .tx_ready_i  (tx_ready_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_dev_o   (cmd_dev_o),
  .cmd_reg_o   (cmd_reg_o),
  .cmd_dat_o   (cmd_dat_o),
  .cmd_ready_i (cmd_ready_i),
  .reinit_o    (reinit_o),
  .rx_acc      (rx_acc),
  .log_acc     (log_acc),
  .rd_acc      (rd_acc),
  .line_cnt    (line_cnt)
);

// File: tb/test_ted_term_editor.sv
`timescale 1ns/1ps
module test_ted_term_editor;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       rx_valid = 0;
  logic [7:0] rx_data = 0;
  logic       rx_ready;
  logic       log_valid = 0;
  logic [7:0] log_dev = 0, log_reg = 0, log_dat = 0;
  logic       log_ready;
  logic       rd_valid = 0;
  logic [7:0] rd_data = 0;
  logic       rd_ready;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 0;
  logic       cmd_valid;
  logic [7:0] cmd_dev, cmd_reg, cmd_dat;
  logic       cmd_read;
  logic       cmd_ready = 0;
  logic       reinit;

  ted_term_editor i_ted_term_editor (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .log_valid_i(log_valid), .log_dev_i(log_dev), .log_reg_i(log_reg), .log_dat_i(log_dat),
    .log_ready_o(log_ready),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .rd_ready_o(rd_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .cmd_valid_o(cmd_valid), .cmd_dev_o(cmd_dev), .cmd_reg_o(cmd_reg), .cmd_dat_o(cmd_dat),
    .cmd_read_o(cmd_read), .cmd_ready_i(cmd_ready), .reinit_o(reinit)
  );

  always #2.5 clk = ~clk;

  int   total = 0, bad = 0;
  byte  got_q[$];
  int   cmd_n = 0, reinit_n = 0;
  logic [23:0] last_cmd;
  logic        last_rd;
  logic        run_monitor = 1;

  // bench line model
  logic [23:0] m_line = '0;
  int          m_cnt = 0;
  bit          m_commit, m_esc;

  always @(negedge clk) begin
    tx_ready  = ($urandom % 4) != 0;
    cmd_ready = ($urandom % 3) != 0;
  end

  always @(negedge clk) begin
    #1.5;
    if (rst_n && run_monitor) begin
      if (tx_valid && tx_ready) got_q.push_back(tx_data);
      if (cmd_valid && cmd_ready) begin
        cmd_n++;
        last_cmd = {cmd_dev, cmd_reg, cmd_dat};
        last_rd  = cmd_read;
      end
      if (reinit) reinit_n++;
    end
  end

  function automatic string hexs(input string s);
    string r = "";
    for (int i = 0; i < s.len(); i++) r = $sformatf("%s%02h ", r, s[i]);
    return r;
  endfunction

  function automatic byte hch(input int v);
    string hx = "0123456789ABCDEF";
    return hx[v];
  endfunction

  function automatic string line_txt(input int n);
    string s = "";
    for (int i = 0; i < n; i++) s = $sformatf("%s%c", s, hch(int'(m_line[23-4*i -: 4])));
    return s;
  endfunction

  function automatic int hexval(input byte c);
    if (c >= 8'h30 && c <= 8'h39) return c - 8'h30;
    if (c >= 8'h41 && c <= 8'h46) return c - 8'h37;
    if (c >= 8'h61 && c <= 8'h66) return c - 8'h57;
    return -1;
  endfunction

  function automatic string exp_key(input byte c);
    string s = "";
    int v = hexval(c);
    m_commit = 0;
    m_esc = 0;
    if (v >= 0) begin
      if (m_cnt < 6) begin
        m_line[23-4*m_cnt -: 4] = v[3:0];
        m_cnt++;
        s = $sformatf("%c", hch(v));
      end
    end else if (c == 8'h57 || c == 8'h77 || c == 8'h52 || c == 8'h72) begin
      m_line[16] = (c == 8'h52 || c == 8'h72);
      s = $sformatf("%c%s", 8'h0D, line_txt(m_cnt));
    end else if (c == 8'h08 || c == 8'h7F) begin
      if (m_cnt > 0) begin
        m_cnt--;
        s = $sformatf("%c%c%c", 8'h08, 8'h20, 8'h08);
      end
    end else if (c == 8'h0D) begin
      if (m_cnt == 6) begin
        m_commit = 1;
        s = $sformatf("%c%c", 8'h0D, 8'h0A);
      end
    end else if (c == 8'h1B) begin
      m_cnt = 0;
      m_esc = 1;
      s = $sformatf("%c%c", 8'h0D, 8'h0A);
    end
    return s;
  endfunction

  function automatic string exp_log(input logic [23:0] v);
    m_line = v;
    m_cnt = 6;
    return $sformatf("%s%c%c", line_txt(6), 8'h0D, 8'h0A);
  endfunction

  function automatic string exp_rd(input logic [7:0] b);
    return $sformatf("%c%c%c%c", hch(int'(b[7:4])), hch(int'(b[3:0])), 8'h0D, 8'h0A);
  endfunction

  task automatic check(input bit ok, input string req, input string act, input string expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, expv);
    end
  endtask

  task automatic expect_out(input string expv, input string req);
    string g = "";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (got_q.size() >= expv.len() && expv.len() > 0) break;
      if (expv.len() == 0 && i >= 20) break;
    end
    repeat (12) @(negedge clk);
    #2;
    foreach (got_q[i]) g = $sformatf("%s%c", g, got_q[i]);
    got_q.delete();
    check(g == expv, req, hexs(g), hexs(expv));
  endtask

  task automatic send_key(input byte c);
    @(negedge clk);
    rx_data = c;
    rx_valid = 1;
    forever begin
      #1.5;
      if (rx_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic send_log(input logic [23:0] v);
    @(negedge clk);
    {log_dev, log_reg, log_dat} = v;
    log_valid = 1;
    forever begin
      #1.5;
      if (log_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    log_valid = 0;
  endtask

  task automatic send_rd(input logic [7:0] b);
    @(negedge clk);
    rd_data = b;
    rd_valid = 1;
    forever begin
      #1.5;
      if (rd_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic key_step(input byte c, input string req);
    string e;
    int pc = cmd_n, pr = reinit_n;
    e = exp_key(c);
    send_key(c);
    expect_out(e, req);
    if (m_commit) begin
      check(cmd_n == pc + 1 && last_cmd == m_line && last_rd == m_line[16], "R6 command",
            $sformatf("n=%0d %h rd=%b", cmd_n - pc, last_cmd, last_rd),
            $sformatf("n=1 %h rd=%b", m_line, m_line[16]));
    end else begin
      check(cmd_n == pc, "R6 no command", $sformatf("%0d", cmd_n - pc), "0");
    end
    check(reinit_n == pr + (m_esc ? 1 : 0), "R8 reinit pulses",
          $sformatf("%0d", reinit_n - pr), $sformatf("%0d", m_esc ? 1 : 0));
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    string e;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1.5;
    // R1 reset state
    check(!tx_valid && !cmd_valid && !reinit && rx_ready, "R1 reset outputs",
          $sformatf("%b%b%b%b", tx_valid, cmd_valid, reinit, rx_ready), "0001");
    key_step(8'h0D, "R1 enter on empty line");

    // R2 log entry loads line
    send_log(24'h12AB5C);
    expect_out(exp_log(24'h12AB5C), "R2 log print");
    key_step("7", "R3 digit on full line ignored");
    key_step(8'h7F, "R4 delete removes digit");
    key_step("e", "R3 lower-case digit echo");
    key_step("W", "R5 W clears bit0");
    key_step("r", "R5 r sets bit0");
    key_step(8'h0D, "R6 commit read");
    key_step("w", "R5 w clears bit0");
    key_step(8'h0D, "R6 commit write");
    key_step("z", "R7 junk ignored");
    key_step(" ", "R7 space ignored");
    key_step("R", "R7 line unchanged after junk");

    // R8 ESC, then empty line behaviour
    key_step(8'h1B, "R8 escape");
    key_step(8'h08, "R4 backspace on empty line");
    key_step("R", "R5 set bit0 before digit entered");
    key_step("0", "R3 digit 0");
    key_step("F", "R3 upper-case digit");
    key_step("w", "R5 partial line redraw");
    key_step(8'h0D, "R6 enter on partial line");

    // R9 read data
    send_rd(8'h3C);
    expect_out(exp_rd(8'h3C), "R9 read data print");

    // R10 simultaneous inputs
    e = exp_rd(8'hD7);
    e = {e, exp_log(24'hA01122)};
    e = {e, exp_key("r")};
    fork
      send_rd(8'hD7);
      send_log(24'hA01122);
      send_key("r");
    join
    expect_out(e, "R10 acceptance order");

    // random mix, R11 stalls via random tx_ready
    for (int n = 0; n < 400; n++) begin
      int r = $urandom % 100;
      byte c;
      if (r < 45) begin
        int v = $urandom % 16;
        c = (v < 10) ? byte'(8'h30 + v) : byte'((($urandom % 2) ? 8'h41 : 8'h61) + v - 10);
        key_step(c, "R3 random digit");
      end else if (r < 55) begin
        byte ks[4] = '{8'h57, 8'h77, 8'h52, 8'h72};
        key_step(ks[$urandom % 4], "R5 random rw key");
      end else if (r < 68) begin
        key_step(($urandom % 2) ? 8'h08 : 8'h7F, "R4 random backspace");
      end else if (r < 78) begin
        key_step(8'h0D, "R6 random enter");
      end else if (r < 80) begin
        key_step(8'h1B, "R8 random escape");
      end else if (r < 88) begin
        byte js[5] = '{8'h7A, 8'h47, 8'h0A, 8'h20, 8'h71};
        key_step(js[$urandom % 5], "R7 random junk");
      end else if (r < 94) begin
        logic [7:0] b = 8'($urandom);
        send_rd(b);
        expect_out(exp_rd(b), "R9 random read data");
      end else begin
        logic [23:0] v = 24'($urandom);
        send_log(v);
        expect_out(exp_log(v), "R2 random log");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule